// File: doc/BRIEF.md
# 4x4 Forward Walsh-Hadamard Transform

This block turns one 4x4 block of signed 16-bit residual samples into 16 signed 16-bit coefficients with an integer Walsh-Hadamard transform. The transform uses only additions, subtractions and one halving step, which makes it suitable for lossless coding paths. The whole block arrives in a single input beat, in row-major order. The 16 coefficients leave in a single output beat, also in row-major order.

The work is done iteratively with one bank of four lifting units. The first cycle runs the column pass and writes its result to the work register, reordered and transposed. The second cycle runs the row pass on that register, scales each result by four, saturates it and writes it back in output order. The block then holds the result until the consumer accepts it, and only after that does it take the next block.

Top module: `wht4_fwd`

## Requirements
- R1: `in_ready` is high only while the block is idle. After a beat is accepted (`in_valid && in_ready` at a rising edge), `in_ready` stays low until the result has been handed off. It is high again in the cycle after the edge where `out_valid && out_ready` holds.
- R2: `out_valid` goes high after the third rising edge, counting the accepting edge as the first.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R4: The first pass works on each column j, taking rows 0..3 as a,b,c,d. It computes, in order: a=a+b; d=d-c; e=(a-d)>>1; b=e-b; c=e-c; a=a-c; d=d+b.
- R5: The results of the first pass are stacked as rows a,c,d,b and transposed. The same lifting sequence then runs on every lane of that transposed data, with transposed rows 0,3,1,2 taking the roles a,b,c,d.
- R6: Each result of the second pass is multiplied by 4. The results are stacked as rows a,d,b,c and transposed to give the output. Element (row r, column c) sits at bits [(4r+c)*16 +: 16] of both `in_data` and `out_data`.
- R7: A scaled coefficient outside the signed 16-bit range is clamped to 32767 or -32768. Intermediate values never wrap.
- R8: The halving step is an arithmetic right shift, so an odd negative difference rounds toward minus infinity (for example, -1 halves to -1).
- R9: A beat offered on `in_valid` while the block is busy is not taken and does not affect the result in flight.
- R10: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Block can accept a new input block |
| in_data | input | 256 | 16 signed samples, row-major, element k at bits [16k +: 16] |
| out_valid | output | 1 | Coefficient block available |
| out_ready | input | 1 | Consumer accepts the coefficient block |
| out_data | output | 256 | 16 signed coefficients, row-major, element k at bits [16k +: 16] |

## Verification
The bench drives single-sample impulses of +1, -1, the largest and the smallest value at every position. Any mistake in lane routing, in the a,c,d,b or a,d,b,c reordering, or in a transpose then shows up as a coefficient landing in the wrong place or with the wrong sign. Blocks of small values between -4 and 3 produce many odd negative differences, which catch a halving step that truncates toward zero. Uniform blocks and blocks of alternating extremes drive the results past the 16-bit limits, which catch an output that wraps instead of clamping. Held-off output and a competing beat offered during processing catch a result that changes under backpressure, or a second block that slips into the one in flight.

// File: rtl/wht4_pkg.sv
`timescale 1ns/1ps
package wht4_pkg;
    localparam int WHT_DIM = 4;
    localparam int WHT_NEL = WHT_DIM * WHT_DIM;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COLS = 2'd1,
        ST_ROWS = 2'd2,
        ST_HOLD = 2'd3
    } wht4_state_e;
endpackage

// File: rtl/wht4_lift.sv
`timescale 1ns/1ps
// One four-point lifting Hadamard step with a shared halved difference.
module wht4_lift #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    input  logic signed [W-1:0] c_i,
    input  logic signed [W-1:0] d_i,
    output logic signed [W-1:0] a_o,
    output logic signed [W-1:0] b_o,
    output logic signed [W-1:0] c_o,
    output logic signed [W-1:0] d_o
);
    logic signed [W-1:0] sum_ab;
    logic signed [W-1:0] dif_dc;
    logic signed [W-1:0] half;

    always_comb begin
        sum_ab = a_i + b_i;
        dif_dc = d_i - c_i;
        half   = (sum_ab - dif_dc) >>> 1;
        b_o    = half - b_i;
        c_o    = half - c_i;
        a_o    = sum_ab - c_o;
        d_o    = dif_dc + b_o;
    end
endmodule

// File: rtl/wht4_sat.sv
`timescale 1ns/1ps
// Scale by a power of two, then clamp to the signed output range.
module wht4_sat #(
    parameter int WW = 24,
    parameter int IW = 16,
    parameter int SH = 2
) (
    input  logic signed [WW-1:0] v_i,
    output logic        [WW-1:0] v_o
);
    localparam logic signed [WW-1:0] HI = WW'((64'sd1 <<< (IW - 1)) - 64'sd1);
    localparam logic signed [WW-1:0] LO = ~HI;

    logic signed [WW-1:0] scaled;

    always_comb begin
        scaled = v_i <<< SH;
        if (scaled > HI) begin
            v_o = HI;
        end else if (scaled < LO) begin
            v_o = LO;
        end else begin
            v_o = scaled;
        end
    end
endmodule

// File: rtl/wht4_fwd.sv
`timescale 1ns/1ps
module wht4_fwd
    import wht4_pkg::*;
#(
    parameter int IW    = 16,
    parameter int GUARD = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [WHT_NEL*IW-1:0]   in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WHT_NEL*IW-1:0]   out_data
);
    localparam int WW = IW + GUARD;
    localparam int SCALE_SH = 2;

    typedef struct packed {
        wht4_state_e                 st;
        logic [WHT_NEL-1:0][WW-1:0]  mat;
    } regs_t;

    regs_t r_q, r_d;

    // lifter lanes, shared by both passes
    logic [WHT_DIM-1:0][WW-1:0] l_a, l_b, l_c, l_d;
    logic [WHT_DIM-1:0][WW-1:0] q_a, q_b, q_c, q_d;
    logic [WHT_NEL-1:0][WW-1:0] sat_in, sat_out;

    // operand routing: columns in the first pass, reordered rows in the second
    always_comb begin
        for (int g = 0; g < WHT_DIM; g++) begin
            if (r_q.st == ST_COLS) begin
                l_a[g] = r_q.mat[0*WHT_DIM + g];
                l_b[g] = r_q.mat[1*WHT_DIM + g];
                l_c[g] = r_q.mat[2*WHT_DIM + g];
                l_d[g] = r_q.mat[3*WHT_DIM + g];
            end else begin
                l_a[g] = r_q.mat[g*WHT_DIM + 0];
                l_b[g] = r_q.mat[g*WHT_DIM + 3];
                l_c[g] = r_q.mat[g*WHT_DIM + 1];
                l_d[g] = r_q.mat[g*WHT_DIM + 2];
            end
        end
    end

    generate
        for (genvar g = 0; g < WHT_DIM; g++) begin : g_lane
            wht4_lift #(.W(WW)) u_lift (
                .a_i (l_a[g]),
                .b_i (l_b[g]),
                .c_i (l_c[g]),
                .d_i (l_d[g]),
                .a_o (q_a[g]),
                .b_o (q_b[g]),
                .c_o (q_c[g]),
                .d_o (q_d[g])
            );
            // output row g takes lane g results in a,d,b,c order
            assign sat_in[g*WHT_DIM + 0] = q_a[g];
            assign sat_in[g*WHT_DIM + 1] = q_d[g];
            assign sat_in[g*WHT_DIM + 2] = q_b[g];
            assign sat_in[g*WHT_DIM + 3] = q_c[g];
        end
        for (genvar k = 0; k < WHT_NEL; k++) begin : g_el
            wht4_sat #(.WW(WW), .IW(IW), .SH(SCALE_SH)) u_sat (
                .v_i (sat_in[k]),
                .v_o (sat_out[k])
            );
            assign out_data[k*IW +: IW] = r_q.mat[k][IW-1:0];
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    for (int k = 0; k < WHT_NEL; k++) begin
                        r_d.mat[k] = {{GUARD{in_data[k*IW + IW - 1]}}, in_data[k*IW +: IW]};
                    end
                    r_d.st = ST_COLS;
                end
            end
            ST_COLS: begin
                // rows stored as a,c,d,b; lane g is column g
                for (int g = 0; g < WHT_DIM; g++) begin
                    r_d.mat[0*WHT_DIM + g] = q_a[g];
                    r_d.mat[1*WHT_DIM + g] = q_c[g];
                    r_d.mat[2*WHT_DIM + g] = q_d[g];
                    r_d.mat[3*WHT_DIM + g] = q_b[g];
                end
                r_d.st = ST_ROWS;
            end
            ST_ROWS: begin
                r_d.mat = sat_out;
                r_d.st  = ST_HOLD;
            end
            ST_HOLD: begin
                if (out_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mat: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_IDLE);
    assign out_valid = (r_q.st == ST_HOLD);
endmodule

// File: rtl/wht4_fwd_chk.sv
`timescale 1ns/1ps
module wht4_fwd_chk #(
    parameter int IW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [16*IW-1:0] out_data
);
    // R1: accepting a beat makes the block busy
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R1: a handoff returns the block to idle
    a_r1_idle_after_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R2: a new result follows an acceptance three edges earlier
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 3));

    // R3: result held under backpressure
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9: no acceptance while a result waits
    a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

bind wht4_fwd wht4_fwd_chk #(.IW(IW)) u_wht4_fwd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/wht4_fwd_test.sv
`timescale 1ns/1ps
module wht4_fwd_test;
    localparam int IW = 16;
    localparam int NE = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [NE*IW-1:0] in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [NE*IW-1:0] out_data;

    int total = 0;
    int bad = 0;
    int blk [NE];
    int expv [NE];

    wht4_fwd #(.IW(IW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always #5 clk = ~clk;

    function automatic int clamp16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic void step(input int a, input int b, input int c, input int d,
                                 output int ao, output int bo, output int co, output int dd);
        int e;
        a  = a + b;
        d  = d - c;
        e  = (a - d) >>> 1;
        b  = e - b;
        c  = e - c;
        a  = a - c;
        d  = d + b;
        ao = a; bo = b; co = c; dd = d;
    endfunction

    // literal reading: pass, stack rows, transpose, pass, scale, stack rows, transpose
    function automatic void ref_model();
        int p [4][4];
        int t [4][4];
        int n [4][4];
        int a, b, c, d;
        for (int j = 0; j < 4; j++) begin
            step(blk[j], blk[4+j], blk[8+j], blk[12+j], a, b, c, d);
            p[0][j] = a; p[1][j] = c; p[2][j] = d; p[3][j] = b;
        end
        for (int r = 0; r < 4; r++)
            for (int q = 0; q < 4; q++)
                t[r][q] = p[q][r];
        for (int m = 0; m < 4; m++) begin
            step(t[0][m], t[3][m], t[1][m], t[2][m], a, b, c, d);
            n[0][m] = 4 * a; n[1][m] = 4 * d; n[2][m] = 4 * b; n[3][m] = 4 * c;
        end
        for (int r = 0; r < 4; r++)
            for (int q = 0; q < 4; q++)
                expv[r*4 + q] = clamp16(n[q][r]);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp_val);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_val);
        end
    endtask

    task automatic run_block(input string req, input int stall, input bit poke);
        logic [NE*IW-1:0] held;
        int bad_k;
        int act;
        ref_model();
        @(negedge clk);
        for (int k = 0; k < NE; k++) in_data[k*IW +: IW] = IW'(blk[k]);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);                        // accepting edge has passed
        if (poke) in_data = ~in_data;          // R9: competing beat while busy
        else      in_valid = 1'b0;
        check(!in_ready && !out_valid, "R1", "busy after accept", int'(in_ready), 0);
        @(negedge clk);
        check(!out_valid, "R2", "out_valid early", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid, "R2", "out_valid on third edge", int'(out_valid), 1);
        in_valid = 1'b0;
        bad_k = -1;
        act = 0;
        for (int k = 0; k < NE; k++) begin
            if ($signed(out_data[k*IW +: IW]) != expv[k] && bad_k < 0) begin
                bad_k = k;
                act = $signed(out_data[k*IW +: IW]);
            end
        end
        check(bad_k < 0, req, "coefficient", act, (bad_k < 0) ? 0 : expv[bad_k]);
        held = out_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(out_valid && (out_data == held), "R3", "hold under backpressure",
                  int'(out_valid), 1);
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R1", "idle after handoff", int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
        check(out_data == '0, "R10", "out_data after reset", int'(out_data[15:0]), 0);

        // zero block
        for (int k = 0; k < NE; k++) blk[k] = 0;
        run_block("R4,R5,R6 zero", 0, 1'b0);

        // R7: uniform extremes clamp
        for (int k = 0; k < NE; k++) blk[k] = 32767;
        run_block("R7 all-max", 2, 1'b0);
        for (int k = 0; k < NE; k++) blk[k] = -32768;
        run_block("R7 all-min", 0, 1'b0);
        for (int k = 0; k < NE; k++) blk[k] = ((k + k/4) % 2) ? -32768 : 32767;
        run_block("R7 checkerboard", 0, 1'b0);

        // R8: single -1 in the corner, halving must floor
        for (int k = 0; k < NE; k++) blk[k] = 0;
        blk[0] = -1;
        run_block("R8 corner -1", 0, 1'b0);

        // R4, R5, R6: impulse sweep over every position and four amplitudes
        for (int pos = 0; pos < NE; pos++) begin
            for (int v = 0; v < 4; v++) begin
                for (int k = 0; k < NE; k++) blk[k] = 0;
                blk[pos] = (v == 0) ? 1 : (v == 1) ? -1 : (v == 2) ? 32767 : -32768;
                run_block("R4,R5,R6 impulse", 0, 1'b0);
            end
        end

        // R8: small signed values, many odd negative differences
        for (int i = 0; i < 150; i++) begin
            for (int k = 0; k < NE; k++) blk[k] = int'($urandom_range(7)) - 4;
            run_block("R8 small", 0, 1'b0);
        end

        // full-range random blocks, with backpressure and competing beats
        for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < NE; k++) blk[k] = int'($urandom_range(65535)) - 32768;
            if (i % 3 == 0)      run_block("R9 busy poke", 1, 1'b1);
            else if (i % 3 == 1) run_block("R3,R7 random", 3, 1'b0);
            else                 run_block("R4,R5,R6 random", 0, 1'b0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule